// File: doc/BRIEF.md
# Codec Input Frame Serializer

This block produces the codec-to-controller direction of a serial audio link. It forms a 256-bit frame and shifts it onto one serial data line, one bit per bit clock. A frame begins with a 16-bit tag slot and continues with twelve 20-bit data slots. The tag carries a codec-ready flag and one valid tag per data slot. Slot 1 echoes the index of the register whose contents are being returned, and slot 2 carries that register's 16-bit value. Slots 3 and 4 carry the left and right 18-bit converter samples. Slots 5 to 12 are unused.

A frame starts when the frame sync is sampled high on a rising bit-clock edge. Every input is captured on that same edge, and the first tag bit leaves on the next rising edge. Bits change on rising edges so the controller can sample them on falling edges. Once the last bit of slot 12 has been on the line for its full cycle, a one-cycle frame-done strobe tells upstream logic it may load the next register response and samples. A sync that arrives together with the launch of the final bit starts the next frame with no gap.

Top module: `cif_serializer`

## Requirements
- R1: While reset is asserted and after it is released with no sync, `sdata_o` and `frame_done_o` are 0.
- R2: When `sync_i` is sampled high on rising edge N with no frame in progress, the line stays 0 until edge N+1. Frame bit 255 (the ready flag) is launched on edge N+1, and frame bit 255-k is launched on edge N+1+k, so frame bits leave MSB first.
- R3: Frame bits 255:240 form the tag. Bit 255 is `codec_ready_i`. Bits 254, 253, 252 and 251 are the valid tags of slots 1 to 4 and take the values of `rd_idx_vld_i`, `rd_data_vld_i`, `adc_l_vld_i` and `adc_r_vld_i`. Bits 250:240 are 0.
- R4: Slot 1 occupies frame bits 239:220, written here as slot bits 19:0. Slot bit 19 is 0, slot bits 18:12 hold `rd_idx_i`, and slot bits 11:0 are 0.
- R5: Slot 2 occupies frame bits 219:200. Slot bits 19:4 hold `rd_data_i` and slot bits 3:0 are 0.
- R6: Slot 3 occupies frame bits 199:180 and slot 4 occupies frame bits 179:160. Slot bits 19:2 hold `adc_l_i` in slot 3 and `adc_r_i` in slot 4, and slot bits 1:0 are 0.
- R7: Frame bits 159:0, which make up slots 5 to 12, are always 0.
- R8: A data slot whose valid tag is 0 is sent as all zeros, whatever its input holds.
- R9: Every input, including the valid flags and the ready flag, is captured on the sync edge. Changes made later in the frame have no effect on that frame.
- R10: `frame_done_o` is high for exactly one cycle. That cycle follows the cycle in which frame bit 0 is on the line.
- R11: `sync_i` has no effect while a frame is in progress, with one exception. It is accepted on the edge that launches frame bit 0, and the next frame's bit 255 then follows on the very next edge.
- R12: When no frame is in progress, `sdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; bits launch on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync, sampled on the rising edge |
| codec_ready_i | input | 1 | Codec-ready flag for the tag |
| rd_idx_i | input | 7 | Index of the register being returned |
| rd_idx_vld_i | input | 1 | Valid tag for slot 1 |
| rd_data_i | input | 16 | Register read data |
| rd_data_vld_i | input | 1 | Valid tag for slot 2 |
| adc_l_i | input | 18 | Left converter sample |
| adc_l_vld_i | input | 1 | Valid tag for slot 3 |
| adc_r_i | input | 18 | Right converter sample |
| adc_r_vld_i | input | 1 | Valid tag for slot 4 |
| sdata_o | output | 1 | Serial frame data |
| frame_done_o | output | 1 | One-cycle strobe after the last bit of a frame |

## Verification
The hardest case to reach is the edge that launches frame bit 0 while also accepting a new sync. On that edge the old frame's final bit has to go out while the new frame is loaded. The bench reaches it by counting captured bits and raising sync just before the rising edge that launches bit 0. It changes the inputs at the same moment. It then checks that the old frame ends intact and that the new frame follows with no idle bit. It also checks that the done strobe lands on the new frame's first bit. Two other cases are reached by changing inputs, or pulsing sync, at fixed bit counts in mid-frame, where each should have no effect.

// File: rtl/cif_pkg.sv
`timescale 1ns/1ps
package cif_pkg;
  localparam int unsigned TAG_W   = 16;
  localparam int unsigned SLOT_W  = 20;
  localparam int unsigned N_SLOTS = 12;
  localparam int unsigned IDX_W   = 7;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADC_W   = 18;
  localparam int unsigned BODY_W  = N_SLOTS * SLOT_W;
  localparam int unsigned FRAME_W = TAG_W + BODY_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  // fixed slot roles (0-based: slot 1 is index 0)
  localparam int unsigned S_IDX   = 0;
  localparam int unsigned S_DATA  = 1;
  localparam int unsigned S_LEFT  = 2;
  localparam int unsigned S_RIGHT = 3;
endpackage

// File: rtl/cif_slot_pack.sv
`timescale 1ns/1ps
module cif_slot_pack
  import cif_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              idx_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_vld_i,
  input  logic [ADC_W-1:0]  left_i,
  input  logic              left_vld_i,
  input  logic [ADC_W-1:0]  right_i,
  input  logic              right_vld_i,
  output logic [BODY_W-1:0] body_o,   // slot 1 at the MSB end
  output logic [N_SLOTS-1:0] vld_o    // slot 1 at the MSB end
);
  localparam int unsigned IDX_LO  = SLOT_W - 1 - IDX_W;
  localparam int unsigned DATA_LO = SLOT_W - DATA_W;
  localparam int unsigned ADC_LO  = SLOT_W - ADC_W;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] raw;
    logic              vld;
    if (s == S_IDX) begin : g_idx
      assign raw = {1'b0, idx_i, {IDX_LO{1'b0}}};
      assign vld = idx_vld_i;
    end else if (s == S_DATA) begin : g_data
      assign raw = {data_i, {DATA_LO{1'b0}}};
      assign vld = data_vld_i;
    end else if (s == S_LEFT) begin : g_left
      assign raw = {left_i, {ADC_LO{1'b0}}};
      assign vld = left_vld_i;
    end else if (s == S_RIGHT) begin : g_right
      assign raw = {right_i, {ADC_LO{1'b0}}};
      assign vld = right_vld_i;
    end else begin : g_unused
      assign raw = '0;
      assign vld = 1'b0;
    end
    assign vld_o[N_SLOTS-1-s] = vld;
    assign body_o[(N_SLOTS-s)*SLOT_W-1 -: SLOT_W] = vld ? raw : '0;
  end
endmodule

// File: rtl/cif_shifter.sv
`timescale 1ns/1ps
module cif_shifter
  import cif_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o,
  output logic               done_o,
  output logic               busy_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, sdata_q, last_q, done_q;
  logic               at_last, load;

  assign at_last = busy_q && (cnt_q == LAST);
  assign load    = sync_i && (!busy_q || at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      sdata_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sdata_q <= busy_q ? sh_q[FRAME_W-1] : 1'b0;
      last_q  <= at_last;
      done_q  <= last_q;
      if (load) begin
        sh_q   <= frame_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
        cnt_q  <= cnt_q + 1'b1;
        busy_q <= !at_last;
      end
    end
  end

  assign sdata_o = sdata_q;
  assign done_o  = done_q;
  assign busy_o  = busy_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/cif_serializer.sv
`timescale 1ns/1ps
module cif_serializer
  import cif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              codec_ready_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              rd_idx_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_data_vld_i,
  input  logic [ADC_W-1:0]  adc_l_i,
  input  logic              adc_l_vld_i,
  input  logic [ADC_W-1:0]  adc_r_i,
  input  logic              adc_r_vld_i,
  output logic              sdata_o,
  output logic              frame_done_o
);
  localparam int unsigned TAG_PAD = TAG_W - 1 - N_SLOTS;

  logic [BODY_W-1:0]  body_w;
  logic [N_SLOTS-1:0] vld_w;
  logic [TAG_W-1:0]   tag_w;
  logic [FRAME_W-1:0] frame_w;
  logic               busy_w;
  logic [CNT_W-1:0]   cnt_w;

  cif_slot_pack u_pack (
    .idx_i       (rd_idx_i),
    .idx_vld_i   (rd_idx_vld_i),
    .data_i      (rd_data_i),
    .data_vld_i  (rd_data_vld_i),
    .left_i      (adc_l_i),
    .left_vld_i  (adc_l_vld_i),
    .right_i     (adc_r_i),
    .right_vld_i (adc_r_vld_i),
    .body_o      (body_w),
    .vld_o       (vld_w)
  );

  assign tag_w   = {codec_ready_i, vld_w, {TAG_PAD{1'b0}}};
  assign frame_w = {tag_w, body_w};

  cif_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .frame_i (frame_w),
    .sdata_o (sdata_o),
    .done_o  (frame_done_o),
    .busy_o  (busy_w),
    .cnt_o   (cnt_w)
  );
endmodule

// File: rtl/cif_serializer_chk.sv
`timescale 1ns/1ps
module cif_serializer_chk
  import cif_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdata_o,
  input logic             frame_done_o,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam int unsigned TAG_LO = FRAME_W - TAG_W;

  // position of the bit currently on the line
  logic [CNT_W-1:0] pos_q;
  logic             shown_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      shown_q <= 1'b0;
    end else begin
      pos_q   <= CNT_W'(FRAME_W - 1 - int'(cnt_i));
      shown_q <= busy_i;
    end
  end

  function automatic logic is_pad(input logic [CNT_W-1:0] p);
    int unsigned pi, off, slot, b;
    pi = int'(p);
    if (pi >= TAG_LO) return (pi - TAG_LO) < (TAG_W - 1 - 4);
    off  = TAG_LO - 1 - pi;
    slot = off / SLOT_W;
    b    = SLOT_W - 1 - (off % SLOT_W);
    case (slot)
      S_IDX:           return (b == SLOT_W - 1) || (b < SLOT_W - 1 - IDX_W);
      S_DATA:          return b < SLOT_W - DATA_W;
      S_LEFT, S_RIGHT: return b < SLOT_W - ADC_W;
      default:         return 1'b1;
    endcase
  endfunction

  // R3 R4 R5 R6 R7: every padding position is driven low
  p_pad_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shown_q && is_pad(pos_q)) |-> !sdata_o);

  p_idle_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shown_q |-> !sdata_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  p_done_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_done_o) |-> $past(shown_q && (pos_q == '0)));

  p_sync_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (cnt_i != CNT_W'(FRAME_W - 1))) |=>
      (busy_i && (cnt_i == CNT_W'($past(cnt_i) + 1'b1))));
endmodule

bind cif_serializer cif_serializer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sdata_o      (sdata_o),
  .frame_done_o (frame_done_o),
  .busy_i       (busy_w),
  .cnt_i        (cnt_w)
);

// File: tb/tb_cif_serializer.sv
`timescale 1ns/1ps
module tb_cif_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic ready = 1'b0;
  logic [6:0]  idx = '0;
  logic        iv = 1'b0;
  logic [15:0] data = '0;
  logic        dv = 1'b0;
  logic [17:0] lft = '0;
  logic        lv = 1'b0;
  logic [17:0] rgt = '0;
  logic        rv = 1'b0;
  logic sdata, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cif_serializer dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .codec_ready_i(ready),
    .rd_idx_i(idx), .rd_idx_vld_i(iv), .rd_data_i(data), .rd_data_vld_i(dv),
    .adc_l_i(lft), .adc_l_vld_i(lv), .adc_r_i(rgt), .adc_r_vld_i(rv),
    .sdata_o(sdata), .frame_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] expect_frame(
      input logic r, input logic [6:0] ix, input logic ixv, input logic [15:0] d,
      input logic dvl, input logic [17:0] a, input logic av, input logic [17:0] b,
      input logic bv);
    logic [255:0] f = '0;
    f[255] = r; f[254] = ixv; f[253] = dvl; f[252] = av; f[251] = bv;
    if (ixv) f[238:232] = ix;
    if (dvl) f[219:204] = d;
    if (av)  f[199:182] = a;
    if (bv)  f[179:162] = b;
    return f;
  endfunction

  function automatic logic [255:0] cur_expect();
    return expect_frame(ready, idx, iv, data, dv, lft, lv, rgt, rv);
  endfunction

  task automatic set_in(input logic r, input logic [6:0] ix, input logic ixv,
                        input logic [15:0] d, input logic dvl, input logic [17:0] a,
                        input logic av, input logic [17:0] b, input logic bv);
    ready = r; idx = ix; iv = ixv; data = d; dv = dvl;
    lft = a; lv = av; rgt = b; rv = bv;
  endtask

  task automatic check_fields(input logic [255:0] rx, input logic [255:0] ex);
    chk(rx[255:240] == ex[255:240], "R3", "tag",     256'(rx[255:240]), 256'(ex[255:240]));
    chk(rx[239:220] == ex[239:220], "R4", "slot1",   256'(rx[239:220]), 256'(ex[239:220]));
    chk(rx[219:200] == ex[219:200], "R5", "slot2",   256'(rx[219:200]), 256'(ex[219:200]));
    chk(rx[199:160] == ex[199:160], "R6", "slot3/4", 256'(rx[199:160]), 256'(ex[199:160]));
    chk(rx[159:0] == '0,            "R7", "slots5-12", 256'(rx[159:0]), 256'(0));
  endtask

  // ev: 0 none, 1 change inputs at bit 100, 2 sync pulse at bit 50
  task automatic run_frame(input int ev, output logic [255:0] rx);
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    chk(sdata == 1'b0, "R2", "line before first bit", 256'(sdata), 256'(0));
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      rx[255-i] = sdata;
      if (i < 255 && done) chk(1'b0, "R10", "early done", 256'(done), 256'(0));
      if (ev == 1 && i == 100)
        set_in(~ready, ~idx, ~iv, ~data, ~dv, ~lft, ~lv, ~rgt, ~rv);
      if (ev == 2 && i == 50) sync = 1'b1;
      if (ev == 2 && i == 51) sync = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b1, "R10", "done after last bit", 256'(done), 256'(1));
    chk(sdata == 1'b0, "R12", "line idle after frame", 256'(sdata), 256'(0));
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", 256'(done), 256'(0));
  endtask

  task automatic t_reset();
    chk(sdata == 1'b0 && done == 1'b0, "R1", "outputs in reset", 256'({sdata, done}), 256'(0));
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(sdata == 1'b0 && done == 1'b0, "R1", "outputs after reset",
          256'({sdata, done}), 256'(0));
    end
  endtask

  task automatic t_all_valid();
    logic [255:0] rx, ex;
    set_in(1'b1, 7'h2A, 1'b1, 16'hBEEF, 1'b1, 18'h2A5C3, 1'b1, 18'h1F00D, 1'b1);
    ex = cur_expect();
    run_frame(0, rx);
    chk(rx[255] == 1'b1, "R2", "first bit is ready flag", 256'(rx[255]), 256'(1));
    check_fields(rx, ex);
  endtask

  task automatic t_all_ones();
    logic [255:0] rx, ex;
    set_in(1'b1, '1, 1'b1, '1, 1'b1, '1, 1'b1, '1, 1'b1);
    ex = cur_expect();
    run_frame(0, rx);
    check_fields(rx, ex);
  endtask

  task automatic t_invalid();
    logic [255:0] rx, ex;
    set_in(1'b0, 7'h55, 1'b1, 16'hFFFF, 1'b0, 18'h3FFFF, 1'b0, 18'h12345, 1'b1);
    ex = cur_expect();
    run_frame(0, rx);
    check_fields(rx, ex);
    chk(rx[219:200] == '0, "R8", "invalid slot2 zero", 256'(rx[219:200]), 256'(0));
    chk(rx[199:180] == '0, "R8", "invalid slot3 zero", 256'(rx[199:180]), 256'(0));
    set_in(1'b1, 7'h7F, 1'b0, 16'h1234, 1'b1, 18'h00001, 1'b1, 18'h3FFFF, 1'b0);
    ex = cur_expect();
    run_frame(0, rx);
    check_fields(rx, ex);
    chk(rx[239:220] == '0, "R8", "invalid slot1 zero", 256'(rx[239:220]), 256'(0));
    chk(rx[179:160] == '0, "R8", "invalid slot4 zero", 256'(rx[179:160]), 256'(0));
  endtask

  task automatic t_latch();
    logic [255:0] rx, ex;
    set_in(1'b1, 7'h11, 1'b1, 16'hA5A5, 1'b1, 18'h0F0F0, 1'b0, 18'h30303, 1'b1);
    ex = cur_expect();
    run_frame(1, rx);
    chk(rx == ex, "R9", "frame unaffected by mid-frame inputs", rx, ex);
  endtask

  task automatic t_mid_sync();
    logic [255:0] rx, ex;
    set_in(1'b1, 7'h03, 1'b1, 16'h0F0F, 1'b1, 18'h20001, 1'b1, 18'h00002, 1'b1);
    ex = cur_expect();
    run_frame(2, rx);
    chk(rx == ex, "R11", "mid-frame sync ignored", rx, ex);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(sdata == 1'b0 && done == 1'b0, "R12", "idle after ignored sync",
          256'({sdata, done}), 256'(0));
    end
  endtask

  task automatic t_chain();
    logic [255:0] rx1, rx2, ex1, ex2;
    set_in(1'b1, 7'h60, 1'b1, 16'hC001, 1'b1, 18'h15555, 1'b1, 18'h2AAAA, 1'b1);
    ex1 = cur_expect();
    ex2 = expect_frame(1'b0, 7'h0C, 1'b1, 16'h8001, 1'b1, 18'h20000, 1'b1, 18'h00001, 1'b0);
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      rx1[255-i] = sdata;
      if (i == 254) begin
        set_in(1'b0, 7'h0C, 1'b1, 16'h8001, 1'b1, 18'h20000, 1'b1, 18'h00001, 1'b0);
        sync = 1'b1;
      end
      if (i == 255) sync = 1'b0;
    end
    for (int j = 0; j < 256; j++) begin
      @(negedge clk);
      rx2[255-j] = sdata;
      if (j == 0) chk(done == 1'b1, "R10", "done on chained start", 256'(done), 256'(1));
      if (j == 1) chk(done == 1'b0, "R10", "done width chained", 256'(done), 256'(0));
    end
    chk(rx1 == ex1, "R11", "first of back-to-back frames", rx1, ex1);
    chk(rx2 == ex2, "R11", "second frame with no gap", rx2, ex2);
    check_fields(rx2, ex2);
    @(negedge clk);
    chk(done == 1'b1, "R10", "done after chained frame", 256'(done), 256'(1));
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_all_valid();
    t_all_ones();
    t_invalid();
    t_latch();
    t_mid_sync();
    t_chain();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule